// File: doc/BRIEF.md
# Streaming Sobel Gradient Core

This core takes a raster stream of unsigned grayscale pixels and produces an edge-strength pixel for each one. The stream carries one pixel per clock when `in_valid` is high. `in_sof` marks the first pixel of a frame. Two internal row stores keep the previous two image rows. Together with a three-column shift window, they present a 3x3 neighbourhood to a pair of Sobel kernels. The horizontal kernel `[-1 0 1; -2 0 2; -1 0 1]` finds vertical edges. The vertical kernel `[-1 -2 -1; 0 0 0; 1 2 1]` finds horizontal edges.

The two signed gradients are combined as |Gx| + |Gy| and clipped to the pixel range. The result leaves the block with its own valid strobe after a fixed pipeline delay, one output per input, in input order. For input pixel (row r, column c) of a frame, the output is taken over the window of rows r-2..r and columns c-2..c. Positions where that window is incomplete (r < 2 or c < 2) give 0. The image width is a parameter. The image height follows from the stream.

Top module: `sobel_edge_core`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_pix` is 0.
- R2: Each pixel sampled with `in_valid` high produces exactly one `out_valid` cycle. It appears after the third rising edge, counting the edge that sampled the input. Outputs come in input order.
- R3: Cycles with `in_valid` low do not advance the window, the counters or the row stores. `out_pix` holds its value while `out_valid` is low. A stream with idle gaps gives the same outputs as the same stream sent back to back.
- R4: Gx = (right column) - (left column) of the window, with row weights 1, 2, 1 from top to bottom. A vertical step edge therefore gives |Gx|.
- R5: Gy = (bottom row) - (top row) of the window, with column weights 1, 2, 1 from left to right. A horizontal step edge therefore gives |Gy|.
- R6: The output is |Gx| + |Gy|. A negative gradient contributes its absolute value.
- R7: A magnitude above 255 is output as 255. A magnitude of 255 or less passes unchanged.
- R8: The output for frame position (r, c) is 0 when r < 2 or c < 2. Rows and columns count from 0 at the pixel marked by `in_sof`.
- R9: A pixel with `in_sof` high is position (0, 0) even in the middle of a row or frame. Rows stored before it never reach a later output.
- R10: A uniform image gives 0 at every position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | First pixel of a frame, qualified by `in_valid` |
| in_pix | input | PIX_W | Grayscale input pixel |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | PIX_W | Clipped edge magnitude |

## Verification
The main function is tried with a table of four-column, three-row frames. Each frame yields exactly two complete windows. Uniform, vertical-step, horizontal-step, diagonal-corner, falling-step and full-scale patterns separate the two kernels from each other and from a wrong sign, a missing absolute value or a clip at the wrong point. One frame sits exactly on the clip boundary (254 and 256 before clipping). A taller frame with an irregular pattern is checked against a kernel model written in the bench. The same data sent with idle gaps, and a frame restarted in the middle of a row, show whether the window and the row counters ever use stale data.

// File: rtl/sobel_edge_core.sv
module sobel_edge_core #(
  parameter int IMG_W = 16,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int GRAD_W = PIX_W + 3;
  localparam logic [GRAD_W-1:0] PIX_MAX = GRAD_W'((1 << PIX_W) - 1);

  logic [COL_W-1:0] col_q, cur_col;
  logic [1:0]       row_q, cur_row;
  logic [PIX_W-1:0] row_old [IMG_W];
  logic [PIX_W-1:0] row_prev [IMG_W];
  logic [PIX_W-1:0] win [3][3];
  logic             v1, ok1, v2, ok2;
  logic signed [GRAD_W-1:0] gx, gy, gx_q, gy_q;
  logic [GRAD_W-1:0] ax, ay, mag;
  logic             last_col;

  function automatic logic signed [GRAD_W-1:0] sx(input logic [PIX_W-1:0] v);
    return $signed({3'b000, v});
  endfunction

  assign cur_col  = in_sof ? '0 : col_q;
  assign cur_row  = in_sof ? 2'd0 : row_q;
  assign last_col = (int'(cur_col) == IMG_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= 2'd0;
    end else if (in_valid) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
      end else begin
        col_q <= cur_col + COL_W'(1);
        row_q <= cur_row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      row_prev[cur_col] <= in_pix;
      row_old[cur_col]  <= row_prev[cur_col];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          win[r][c] <= '0;
      ok1 <= 1'b0;
      v1  <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        for (int r = 0; r < 3; r++) begin
          win[r][0] <= win[r][1];
          win[r][1] <= win[r][2];
        end
        win[0][2] <= row_old[cur_col];
        win[1][2] <= row_prev[cur_col];
        win[2][2] <= in_pix;
        ok1 <= (cur_row == 2'd2) && (int'(cur_col) >= 2);
      end
    end
  end

  assign gx = (sx(win[0][2]) + (sx(win[1][2]) <<< 1) + sx(win[2][2]))
            - (sx(win[0][0]) + (sx(win[1][0]) <<< 1) + sx(win[2][0]));
  assign gy = (sx(win[2][0]) + (sx(win[2][1]) <<< 1) + sx(win[2][2]))
            - (sx(win[0][0]) + (sx(win[0][1]) <<< 1) + sx(win[0][2]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      ok2  <= 1'b0;
      gx_q <= '0;
      gy_q <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        ok2  <= ok1;
        gx_q <= gx;
        gy_q <= gy;
      end
    end
  end

  assign ax  = gx_q[GRAD_W-1] ? $unsigned(-gx_q) : $unsigned(gx_q);
  assign ay  = gy_q[GRAD_W-1] ? $unsigned(-gy_q) : $unsigned(gy_q);
  assign mag = ax + ay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v2;
      if (v2)
        out_pix <= !ok2 ? '0 : (mag > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : mag[PIX_W-1:0];
    end
  end
endmodule

module sobel_edge_core_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_pix == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_pix));

  // R8
  sof_origin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && in_sof, 3)) |-> (out_pix == '0));
endmodule

bind sobel_edge_core sobel_edge_core_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/test_sobel_edge_core.sv
module test_sobel_edge_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  // each row: 12 pixels of a 4x3 frame, then outputs at (2,2) and (2,3)
  localparam logic [7:0] VEC [0:6][0:13] = '{
    '{100,100,100,100, 100,100,100,100, 100,100,100,100,   0,   0}, // R10 uniform
    '{  0,  0, 50, 50,   0,  0, 50, 50,   0,  0, 50, 50, 200, 200}, // R4 vertical step
    '{  0,  0,  0,  0,   0,  0,  0,  0,  60, 60, 60, 60, 240, 240}, // R5 horizontal step
    '{  0,  0,  0,  0,   0,  0,  0,  0,   0,  0, 40, 40,  80, 160}, // R6 both gradients
    '{  0,  0,255,255,   0,  0,255,255,   0,  0,255,255, 255, 255}, // R7 full scale
    '{ 30, 30,  0,  0,  30, 30,  0,  0,  30, 30,  0,  0, 120, 120}, // R6 negative Gx
    '{  0,  0,  0,  0,   0,  0,  0,  0,   0,  0,127,  1, 254, 255}  // R7 254 passes, 256 clips
  };
  localparam int VREQ [0:6] = '{10, 4, 5, 6, 7, 6, 7};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0;
  int failures = 0;
  int ngot = 0;
  int lat_err = 0;
  bit done = 1'b0;
  logic [7:0] got [0:63];
  logic iv1 = 1'b0, iv2 = 1'b0, iv3 = 1'b0;

  sobel_edge_core #(.IMG_W(W), .PIX_W(8)) i_sobel_edge_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      iv1 <= 1'b0; iv2 <= 1'b0; iv3 <= 1'b0;
    end else begin
      iv1 <= in_valid; iv2 <= iv1; iv3 <= iv2;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid !== iv3) lat_err++;
      if (out_valid === 1'b1 && ngot < 64) begin
        got[ngot] = out_pix;
        ngot++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] p, input bit sof, input int gap);
    in_valid = 1'b1; in_pix = p; in_sof = sof;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic flush();
    repeat (6) @(negedge clk);
  endtask

  function automatic int ref_px(input int img [0:19], input int r, input int c);
    int gx, gy, s;
    int wt [0:2];
    wt = '{1, 2, 1};
    if (r < 2 || c < 2) return 0;
    gx = 0; gy = 0;
    for (int k = 0; k < 3; k++) begin
      gx += wt[k] * (img[(r-2+k)*W + c] - img[(r-2+k)*W + c - 2]);
      gy += wt[k] * (img[r*W + c-2+k] - img[(r-2)*W + c-2+k]);
    end
    s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (s > 255) ? 255 : s;
  endfunction

  task automatic frame_check(input int v, input int gap, input string tag);
    ngot = 0;
    for (int i = 0; i < 12; i++) send(VEC[v][i], i == 0, gap);
    flush();
    chk({tag, " R2 count"}, ngot, 12);
    for (int i = 0; i < 12; i++) begin
      if (i == 10)      chk($sformatf("%s R%0d pos(2,2)", tag, VREQ[v]), int'(got[i]), int'(VEC[v][12]));
      else if (i == 11) chk($sformatf("%s R%0d pos(2,3)", tag, VREQ[v]), int'(got[i]), int'(VEC[v][13]));
      else              chk($sformatf("%s R8 border %0d", tag, i), int'(got[i]), 0);
    end
  endtask

  initial begin
    int img [0:19];
    repeat (3) @(negedge clk);
    // R1
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 out_pix in reset", int'(out_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);

    for (int v = 0; v < 7; v++) frame_check(v, 0, $sformatf("vec%0d", v));

    // R3: same frame with idle gaps
    frame_check(3, 2, "R3 gaps");
    chk("R3 out_pix held while idle", int'(out_pix), int'(VEC[3][13]));

    // R9: frame restarted mid-row, stale rows must not reach outputs
    ngot = 0;
    for (int i = 0; i < 6; i++) send((i % 4 >= 2) ? 8'd255 : 8'd0, i == 0, 0);
    flush();
    ngot = 0;
    for (int i = 0; i < 12; i++) send(8'd0, i == 0, 0);
    flush();
    chk("R9 count", ngot, 12);
    for (int i = 0; i < 12; i++) chk($sformatf("R9 restart pos %0d", i), int'(got[i]), 0);

    // R4 R6 R7 R8: taller irregular frame against the kernel model
    for (int i = 0; i < 20; i++) img[i] = ((i / W) * 53 + (i % W) * (i % W) * 29 + (i / W) * (i % W) * 17) % 256;
    ngot = 0;
    for (int i = 0; i < 20; i++) send(8'(img[i]), i == 0, i % 3);
    flush();
    chk("R2 count tall", ngot, 20);
    for (int i = 0; i < 20; i++)
      chk($sformatf("R6 tall pos(%0d,%0d)", i / W, i % W), int'(got[i]), ref_px(img, i / W, i % W));

    // R2: strobe timing over the whole run
    chk("R2 latency mismatches", lat_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule